// File: doc/BRIEF.md
# Exception Pend and Derived-Exception Resolver

This block keeps the pending state of a small microcontroller interrupt controller. Each exception number has an enable, a priority and pending and active flags. A few numbers keep separate secure and nonsecure copies of that state. A normal pend port marks exceptions pending. A synchronous fault that cannot run at the current execution level is promoted to the hard fault, which is exception 3. The hard fault always has level 0 and is always enabled. A selector runs every cycle and reports the most urgent enabled pending exception as the candidate. It raises a request to the core when the candidate would preempt the running level. An acknowledge pulse makes the candidate active and moves the execution level to the candidate's level.

A second pend port, the derived port, takes faults raised while an exception is being entered and has not yet been acknowledged. The core signals that window on `entry_busy`. On this port a low-urgency debug-monitor fault is discarded. A hard fault raised while a level-0 exception is being entered is terminal, and the block locks up. Every other derived fault goes through the normal pend path, and the ordinary selection then decides between the exception being entered and the derived one. Configuration of enables and priorities comes through a small write port. Urgency levels are priority plus one, so a numerically smaller level is more urgent.

Top module: `exc_pend_unit`

## Requirements
- R1: After reset there is no candidate: `cand_valid`=0, `cand_num`=0, `cand_sec`=0 and `cand_level`=15. Also `irq_req`=0, `exec_level`=15 (idle), `lockup`=0, `der_err`=0 and `active_mask`=0. All enables and priorities are cleared.
- R2: A configuration write to a number of 4 or more sets its enable and priority. Its level becomes priority+1. Number 3, the hard fault, ignores configuration: it always has level 0 and is always enabled.
- R3: A normal pend marks the exception pending, and the outputs change in the cycle after the pend edge. Numbers below 3 are ignored. The candidate is the enabled pending copy with the lowest level. Ties go to the lower number, then to the nonsecure copy. With no candidate, `cand_level` reads 15.
- R4: `irq_req` is high exactly when a candidate exists and its level is strictly below `exec_level`.
- R5: Numbers 4, 6, 11, 14 and 15 are banked: the `sec` flag of a request selects the secure copy (`cand_sec`=1) or the nonsecure copy (`cand_sec`=0). For all other numbers the flag is ignored.
- R6: A normal pend of a synchronous number (4 to 13) is replaced by a pend of the hard fault if that number is disabled or its level is at or above `exec_level`. The requested number then stays not pending.
- R7: An acknowledge with a candidate clears that candidate's pending flag and sets its bit in `active_mask` (bit index = sec*32 + number). It also loads `exec_level` with the candidate's level. Pending flags are cleared only by acknowledge.
- R8: A derived request during `entry_busy` whose number lies outside 3 to 13 is discarded, and `der_err` pulses for one cycle.
- R9: A derived request for number 12, the debug monitor, during `entry_busy` is discarded when its level is at or above `exec_level`. Otherwise it is pended.
- R10: A derived request for number 3 during `entry_busy` asserts `lockup` one cycle later if the current candidate has level 0. Otherwise the hard fault is pended.
- R11: Any other derived request during `entry_busy` follows the normal pend path of R6, promotion included.
- R12: A derived request without `entry_busy` pulses `der_err` and is handled as a normal pend.
- R13: `lockup` holds until reset. While it is set, acknowledge and derived requests have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_num | input | 5 | Exception number to configure |
| cfg_sec | input | 1 | Secure copy select for banked numbers |
| cfg_en | input | 1 | Enable value |
| cfg_prio | input | 3 | Priority value |
| pend_req | input | 1 | Normal pend strobe |
| pend_num | input | 5 | Number to pend |
| pend_sec | input | 1 | Bank flag of the pend |
| der_req | input | 1 | Derived pend strobe |
| der_num | input | 5 | Derived exception number |
| der_sec | input | 1 | Bank flag of the derived pend |
| entry_busy | input | 1 | Exception entry in progress, not yet acknowledged |
| ack | input | 1 | Acknowledge the candidate |
| cand_valid | output | 1 | A candidate exists |
| cand_num | output | 5 | Candidate number |
| cand_sec | output | 1 | Candidate is a secure copy |
| cand_level | output | 4 | Candidate level (15 if none) |
| irq_req | output | 1 | Request to the core |
| exec_level | output | 4 | Current execution level |
| active_mask | output | 64 | Active flag per copy |
| lockup | output | 1 | Sticky lockup |
| der_err | output | 1 | Misused derived request pulse |

## Verification
The bench targets the tie rules of the selector. It checks that equal levels resolve to the nonsecure copy and that a disabled pending copy never wins; a broken comparator would report the wrong number or bank. It drives promotion at the boundary where a synchronous level equals the execution level, where a less-than versus less-or-equal slip would pend the fault itself. On the derived side, the bench separately sets up a debug fault that must be discarded, a hard fault raised over a level-0 entry that must lock up, and a hard fault raised over a lower-urgency entry that must not. It also confirms that an acknowledge during lockup leaves the execution level and the active flags unchanged.

// File: rtl/exc_pend_pkg.sv
package exc_pend_pkg;

    // Fixed exception numbers whose role the logic depends on
    localparam int EXC_HARD       = 3;
    localparam int EXC_DBGMON     = 12;
    localparam int SYNC_END       = 14;   // first asynchronous system number
    localparam int FIRST_PENDABLE = 3;

    typedef enum logic [2:0] {
        RT_NONE,
        RT_PEND,
        RT_PROMOTE,
        RT_DROP,
        RT_LOCK,
        RT_REJECT
    } route_e;

    function automatic logic is_banked(input int n);
        return (n == 4) || (n == 6) || (n == 11) || (n == 14) || (n == 15);
    endfunction

    function automatic logic is_sync(input int n);
        return (n >= EXC_HARD) && (n < SYNC_END);
    endfunction

endpackage

// File: rtl/exc_slots.sv
module exc_slots
    import exc_pend_pkg::*;
#(
    parameter int NUM_EXC = 32,
    parameter int PRIO_W  = 3,
    localparam int NW     = $clog2(NUM_EXC),
    localparam int SW     = NW + 1,
    localparam int SLOTS  = 2 * NUM_EXC,
    localparam int LW     = PRIO_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [SW-1:0]     cfg_slot,
    input  logic              cfg_en,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              set_a,
    input  logic [SW-1:0]     set_a_slot,
    input  logic              set_b,
    input  logic [SW-1:0]     set_b_slot,
    input  logic              clr,
    input  logic [SW-1:0]     clr_slot,
    output logic [SLOTS-1:0]  pend_q,
    output logic [SLOTS-1:0]  en_q,
    output logic [SLOTS-1:0]  act_q,
    output logic [LW-1:0]     lvl_q [SLOTS]
);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam int N = s % NUM_EXC;
        localparam int B = s / NUM_EXC;
        if (N < FIRST_PENDABLE || (B == 1 && !is_banked(N))) begin : g_void
            assign pend_q[s] = 1'b0;
            assign act_q[s]  = 1'b0;
            assign en_q[s]   = 1'b0;
            assign lvl_q[s]  = '1;
        end else begin : g_live
            logic pend_r, act_r, hit_set, hit_clr;
            assign hit_set = (set_a && set_a_slot == SW'(s)) ||
                             (set_b && set_b_slot == SW'(s));
            assign hit_clr = clr && clr_slot == SW'(s);
            // clear first, a same-cycle set wins
            always_ff @(posedge clk) begin
                if (rst) begin
                    pend_r <= 1'b0;
                    act_r  <= 1'b0;
                end else begin
                    if (hit_clr) begin
                        pend_r <= 1'b0;
                        act_r  <= 1'b1;
                    end
                    if (hit_set) pend_r <= 1'b1;
                end
            end
            assign pend_q[s] = pend_r;
            assign act_q[s]  = act_r;
            if (N == EXC_HARD) begin : g_fixed
                assign en_q[s]  = 1'b1;
                assign lvl_q[s] = '0;
            end else begin : g_cfg
                logic              en_r;
                logic [PRIO_W-1:0] prio_r;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        en_r   <= 1'b0;
                        prio_r <= '0;
                    end else if (cfg_we && cfg_slot == SW'(s)) begin
                        en_r   <= cfg_en;
                        prio_r <= cfg_prio;
                    end
                end
                assign en_q[s]  = en_r;
                assign lvl_q[s] = LW'(prio_r) + LW'(1);
            end
        end
    end

    // R7: pending flags fall only under an acknowledge
    a_r7_pend_kept: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (($past(pend_q) & ~pend_q) == '0));

endmodule

// File: rtl/exc_pick.sv
module exc_pick
    import exc_pend_pkg::*;
#(
    parameter int NUM_EXC = 32,
    parameter int PRIO_W  = 3,
    localparam int NW     = $clog2(NUM_EXC),
    localparam int SW     = NW + 1,
    localparam int SLOTS  = 2 * NUM_EXC,
    localparam int LW     = PRIO_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SLOTS-1:0] pend_q,
    input  logic [SLOTS-1:0] en_q,
    input  logic [LW-1:0]    lvl_q [SLOTS],
    output logic             cand_valid,
    output logic [SW-1:0]    cand_slot,
    output logic [LW-1:0]    cand_lvl
);

    // Scan by number, nonsecure copy before secure; strict compare keeps the first
    always_comb begin
        cand_valid = 1'b0;
        cand_slot  = '0;
        cand_lvl   = '1;
        for (int n = 0; n < NUM_EXC; n++) begin
            for (int b = 0; b < 2; b++) begin
                if (pend_q[b*NUM_EXC+n] && en_q[b*NUM_EXC+n] &&
                    (!cand_valid || lvl_q[b*NUM_EXC+n] < cand_lvl)) begin
                    cand_valid = 1'b1;
                    cand_slot  = SW'(b*NUM_EXC+n);
                    cand_lvl   = lvl_q[b*NUM_EXC+n];
                end
            end
        end
    end

    // R3: the reported candidate is a live, enabled pending copy
    a_r3_cand_live: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> (pend_q[cand_slot] && en_q[cand_slot]));

endmodule

// File: rtl/exc_route.sv
module exc_route
    import exc_pend_pkg::*;
#(
    parameter int NUM_EXC = 32,
    parameter int PRIO_W  = 3,
    localparam int NW     = $clog2(NUM_EXC),
    localparam int SW     = NW + 1,
    localparam int SLOTS  = 2 * NUM_EXC,
    localparam int LW     = PRIO_W + 1
) (
    input  logic             req,
    input  logic             derived,
    input  logic             busy,
    input  logic             blocked,
    input  logic [NW-1:0]    num,
    input  logic             sec,
    input  logic [SLOTS-1:0] en_v,
    input  logic [LW-1:0]    lvl_v [SLOTS],
    input  logic [LW-1:0]    exec_lvl,
    input  logic [LW-1:0]    cand_lvl,
    output route_e           act,
    output logic [SW-1:0]    slot,
    output logic             err
);

    localparam logic [LW-1:0] HARD_LVL = '0;

    int            num_i;
    logic [SW-1:0] own_slot;
    logic [LW-1:0] own_lvl;
    logic          own_en, in_entry;

    always_comb begin
        num_i    = 32'(num);
        own_slot = {sec & is_banked(num_i), num};
        own_lvl  = lvl_v[own_slot];
        own_en   = en_v[own_slot];
        in_entry = derived && busy;
        act      = RT_NONE;
        slot     = own_slot;
        err      = 1'b0;
        if (req && !blocked) begin
            if (derived && !busy) err = 1'b1;
            if (in_entry && !is_sync(num_i)) begin
                act = RT_REJECT;
                err = 1'b1;
            end else if (in_entry && num_i == EXC_DBGMON && own_lvl >= exec_lvl) begin
                act = RT_DROP;
            end else if (in_entry && num_i == EXC_HARD && HARD_LVL >= cand_lvl) begin
                act = RT_LOCK;
            end else if (num_i < FIRST_PENDABLE || num_i >= NUM_EXC) begin
                act = RT_NONE;
            end else if (is_sync(num_i) && num_i != EXC_HARD &&
                         (!own_en || own_lvl >= exec_lvl)) begin
                act  = RT_PROMOTE;
                slot = SW'(EXC_HARD);
            end else begin
                act = RT_PEND;
            end
        end
    end

endmodule

// File: rtl/exc_pend_unit.sv
module exc_pend_unit
    import exc_pend_pkg::*;
#(
    parameter int NUM_EXC = 32,
    parameter int PRIO_W  = 3,
    localparam int NW     = $clog2(NUM_EXC),
    localparam int SW     = NW + 1,
    localparam int SLOTS  = 2 * NUM_EXC,
    localparam int LW     = PRIO_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [NW-1:0]     cfg_num,
    input  logic              cfg_sec,
    input  logic              cfg_en,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic              pend_req,
    input  logic [NW-1:0]     pend_num,
    input  logic              pend_sec,
    input  logic              der_req,
    input  logic [NW-1:0]     der_num,
    input  logic              der_sec,
    input  logic              entry_busy,
    input  logic              ack,
    output logic              cand_valid,
    output logic [NW-1:0]     cand_num,
    output logic              cand_sec,
    output logic [LW-1:0]     cand_level,
    output logic              irq_req,
    output logic [LW-1:0]     exec_level,
    output logic [SLOTS-1:0]  active_mask,
    output logic              lockup,
    output logic              der_err
);

    logic [SLOTS-1:0] pend_q, en_q;
    logic [LW-1:0]    lvl_q [SLOTS];
    logic [SW-1:0]    cand_slot;
    logic [LW-1:0]    exec_q;
    logic             lock_q, derr_q, do_ack;

    // path 0: normal pend, path 1: derived pend
    logic          p_req [2];
    logic [NW-1:0] p_num [2];
    logic          p_sec [2];
    route_e        p_act [2];
    logic [SW-1:0] p_slot [2];
    logic [1:0]    p_err, p_set;

    assign p_req[0] = pend_req;
    assign p_num[0] = pend_num;
    assign p_sec[0] = pend_sec;
    assign p_req[1] = der_req;
    assign p_num[1] = der_num;
    assign p_sec[1] = der_sec;

    for (genvar p = 0; p < 2; p++) begin : g_path
        exc_route #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_route (
            .req      (p_req[p]),
            .derived  (p == 1),
            .busy     (entry_busy),
            .blocked  (lock_q),
            .num      (p_num[p]),
            .sec      (p_sec[p]),
            .en_v     (en_q),
            .lvl_v    (lvl_q),
            .exec_lvl (exec_q),
            .cand_lvl (cand_level),
            .act      (p_act[p]),
            .slot     (p_slot[p]),
            .err      (p_err[p])
        );
        assign p_set[p] = (p_act[p] == RT_PEND) || (p_act[p] == RT_PROMOTE);
    end

    assign do_ack = ack && cand_valid && !lock_q;

    exc_slots #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_slot   ({cfg_sec & is_banked(32'(cfg_num)), cfg_num}),
        .cfg_en     (cfg_en),
        .cfg_prio   (cfg_prio),
        .set_a      (p_set[0]),
        .set_a_slot (p_slot[0]),
        .set_b      (p_set[1]),
        .set_b_slot (p_slot[1]),
        .clr        (do_ack),
        .clr_slot   (cand_slot),
        .pend_q     (pend_q),
        .en_q       (en_q),
        .act_q      (active_mask),
        .lvl_q      (lvl_q)
    );

    exc_pick #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_pick (
        .clk        (clk),
        .rst        (rst),
        .pend_q     (pend_q),
        .en_q       (en_q),
        .lvl_q      (lvl_q),
        .cand_valid (cand_valid),
        .cand_slot  (cand_slot),
        .cand_lvl   (cand_level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exec_q <= '1;
            lock_q <= 1'b0;
            derr_q <= 1'b0;
        end else begin
            derr_q <= |p_err;
            if (p_act[1] == RT_LOCK) lock_q <= 1'b1;
            if (do_ack) exec_q <= cand_level;
        end
    end

    assign cand_num   = cand_slot[NW-1:0];
    assign cand_sec   = cand_slot[NW];
    assign irq_req    = cand_valid && (cand_level < exec_q);
    assign exec_level = exec_q;
    assign lockup     = lock_q;
    assign der_err    = derr_q;

    // R13: lockup never falls before reset
    a_r13_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        lockup |=> lockup);

    // R13: acknowledge cannot move the execution level once locked
    a_r13_exec_frozen: assert property (@(posedge clk) disable iff (rst)
        lockup |=> $stable(exec_level));

    // R7: acknowledge loads the level the candidate showed
    a_r7_ack_level: assert property (@(posedge clk) disable iff (rst)
        (ack && cand_valid && !lockup) |=> (exec_level == $past(cand_level)));

    // R12: derived request outside entry is flagged
    a_r12_err_pulse: assert property (@(posedge clk) disable iff (rst)
        (der_req && !entry_busy && !lockup) |=> der_err);

    // R10: lockup only follows a derived hard fault during entry
    a_r10_lock_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(lockup) |-> $past(der_req && entry_busy && der_num == NW'(EXC_HARD)));

endmodule

// File: tb/exc_pend_unit_tb.sv
module exc_pend_unit_tb;

    localparam int CLK_P = 10;
    localparam logic [1:0] OP_CFG = 2'd0, OP_PEND = 2'd1, OP_ACK = 2'd2;

    logic clk = 1'b0;
    logic rst;
    logic cfg_we, cfg_sec, cfg_en, pend_req, pend_sec, der_req, der_sec, entry_busy, ack;
    logic [4:0] cfg_num, pend_num, der_num;
    logic [2:0] cfg_prio;
    logic cand_valid, cand_sec, irq_req, lockup, der_err;
    logic [4:0] cand_num;
    logic [3:0] cand_level, exec_level;
    logic [63:0] active_mask;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    exc_pend_unit #(.NUM_EXC(32), .PRIO_W(3)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_num(cfg_num), .cfg_sec(cfg_sec), .cfg_en(cfg_en), .cfg_prio(cfg_prio),
        .pend_req(pend_req), .pend_num(pend_num), .pend_sec(pend_sec),
        .der_req(der_req), .der_num(der_num), .der_sec(der_sec),
        .entry_busy(entry_busy), .ack(ack),
        .cand_valid(cand_valid), .cand_num(cand_num), .cand_sec(cand_sec),
        .cand_level(cand_level), .irq_req(irq_req), .exec_level(exec_level),
        .active_mask(active_mask), .lockup(lockup), .der_err(der_err)
    );

    typedef struct packed {
        logic [1:0] op;
        logic [4:0] num;
        logic       sec;
        logic       en;
        logic [2:0] prio;
        logic [3:0] rq;
        logic       ev;
        logic [4:0] enm;
        logic       esec;
        logic [3:0] elvl;
        logic       eirq;
        logic [3:0] eexec;
    } vec_t;

    // op num sec en prio | req | valid num sec level irq exec
    localparam vec_t TBL [14] = '{
        '{OP_CFG,  5'd16, 1'b0, 1'b1, 3'd5, 4'd2,  1'b0, 5'd0,  1'b0, 4'd15, 1'b0, 4'd15}, // R2
        '{OP_CFG,  5'd17, 1'b0, 1'b1, 3'd2, 4'd2,  1'b0, 5'd0,  1'b0, 4'd15, 1'b0, 4'd15}, // R2
        '{OP_CFG,  5'd14, 1'b1, 1'b1, 3'd4, 4'd5,  1'b0, 5'd0,  1'b0, 4'd15, 1'b0, 4'd15}, // R5
        '{OP_PEND, 5'd16, 1'b0, 1'b0, 3'd0, 4'd3,  1'b1, 5'd16, 1'b0, 4'd6,  1'b1, 4'd15}, // R3
        '{OP_PEND, 5'd17, 1'b0, 1'b0, 3'd0, 4'd3,  1'b1, 5'd17, 1'b0, 4'd3,  1'b1, 4'd15}, // R3
        '{OP_PEND, 5'd14, 1'b1, 1'b0, 3'd0, 4'd5,  1'b1, 5'd17, 1'b0, 4'd3,  1'b1, 4'd15}, // R5
        '{OP_ACK,  5'd0,  1'b0, 1'b0, 3'd0, 4'd7,  1'b1, 5'd14, 1'b1, 4'd5,  1'b0, 4'd3},  // R7 R4
        '{OP_PEND, 5'd14, 1'b0, 1'b0, 3'd0, 4'd5,  1'b1, 5'd14, 1'b1, 4'd5,  1'b0, 4'd3},  // R5 disabled copy
        '{OP_CFG,  5'd14, 1'b0, 1'b1, 3'd4, 4'd3,  1'b1, 5'd14, 1'b0, 4'd5,  1'b0, 4'd3},  // R3 tie -> nonsecure
        '{OP_CFG,  5'd18, 1'b0, 1'b1, 3'd1, 4'd2,  1'b1, 5'd14, 1'b0, 4'd5,  1'b0, 4'd3},  // R2
        '{OP_PEND, 5'd18, 1'b0, 1'b0, 3'd0, 4'd4,  1'b1, 5'd18, 1'b0, 4'd2,  1'b1, 4'd3},  // R4
        '{OP_ACK,  5'd0,  1'b0, 1'b0, 3'd0, 4'd7,  1'b1, 5'd14, 1'b0, 4'd5,  1'b0, 4'd2},  // R7
        '{OP_PEND, 5'd5,  1'b0, 1'b0, 3'd0, 4'd6,  1'b1, 5'd3,  1'b0, 4'd0,  1'b1, 4'd2},  // R6 disabled
        '{OP_ACK,  5'd0,  1'b0, 1'b0, 3'd0, 4'd7,  1'b1, 5'd14, 1'b0, 4'd5,  1'b0, 4'd0}   // R7
    };

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        cfg_we = 0; cfg_num = 0; cfg_sec = 0; cfg_en = 0; cfg_prio = 0;
        pend_req = 0; pend_num = 0; pend_sec = 0;
        der_req = 0; der_num = 0; der_sec = 0; entry_busy = 0; ack = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1;
        cyc();
        cyc();
        rst = 0;
    endtask

    task automatic do_cfg(input int n, input bit s, input bit e, input int p);
        cfg_we = 1; cfg_num = 5'(n); cfg_sec = s; cfg_en = e; cfg_prio = 3'(p);
        cyc();
        idle_inputs();
    endtask

    task automatic do_pend(input int n, input bit s);
        pend_req = 1; pend_num = 5'(n); pend_sec = s;
        cyc();
        idle_inputs();
    endtask

    task automatic do_der(input int n, input bit s, input bit busy);
        der_req = 1; der_num = 5'(n); der_sec = s; entry_busy = busy;
        cyc();
        idle_inputs();
    endtask

    task automatic do_ack();
        ack = 1;
        cyc();
        idle_inputs();
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_cand(input string tag, input int ev, input int en, input int es,
                            input int el, input int ei, input int ex);
        chk({tag, " cand_valid"}, int'(cand_valid), ev);
        chk({tag, " cand_num"},   int'(cand_num), en);
        chk({tag, " cand_sec"},   int'(cand_sec), es);
        chk({tag, " cand_level"}, int'(cand_level), el);
        chk({tag, " irq_req"},    int'(irq_req), ei);
        chk({tag, " exec_level"}, int'(exec_level), ex);
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk_cand("R1", 0, 0, 0, 15, 0, 15);
        chk("R1 lockup", int'(lockup), 0);
        chk("R1 der_err", int'(der_err), 0);
        chk("R1 active_mask", int'(active_mask == 64'd0), 1);

        // R3: numbers below 3 are not pendable
        do_pend(2, 0);
        chk_cand("R3 low number", 0, 0, 0, 15, 0, 15);

        // table walk
        foreach (TBL[i]) begin
            case (TBL[i].op)
                OP_CFG:  do_cfg(int'(TBL[i].num), TBL[i].sec, TBL[i].en, int'(TBL[i].prio));
                OP_PEND: do_pend(int'(TBL[i].num), TBL[i].sec);
                default: do_ack();
            endcase
            chk_cand($sformatf("R%0d step%0d", TBL[i].rq, i), int'(TBL[i].ev), int'(TBL[i].enm),
                     int'(TBL[i].esec), int'(TBL[i].elvl), int'(TBL[i].eirq), int'(TBL[i].eexec));
        end

        // R2 hard fault ignores configuration; R6 promotion boundary
        do_reset();
        do_cfg(3, 0, 0, 7);
        do_cfg(4, 0, 1, 2);
        do_pend(4, 0);
        chk_cand("R6 runnable sync", 1, 4, 0, 3, 1, 15);
        do_ack();
        chk("R7 active bit", int'(active_mask[4]), 1);
        chk_cand("R7 after ack", 0, 0, 0, 15, 0, 3);
        do_pend(4, 0);
        chk_cand("R6 equal level promoted", 1, 3, 0, 0, 1, 3);
        chk_cand("R2 hard fault level", 1, 3, 0, 0, 1, 3);
        do_ack();
        chk_cand("R6 requested not pending", 0, 0, 0, 15, 0, 0);

        // R8 / R12 / R9 / R11 / R10 / R13 chain
        do_reset();
        do_der(16, 0, 1);
        chk("R8 der_err", int'(der_err), 1);
        chk_cand("R8 ignored", 0, 0, 0, 15, 0, 15);
        cyc();
        chk("R8 der_err one cycle", int'(der_err), 0);

        do_cfg(17, 0, 1, 3);
        do_der(17, 0, 0);
        chk("R12 der_err", int'(der_err), 1);
        chk_cand("R12 pended", 1, 17, 0, 4, 1, 15);

        do_cfg(12, 0, 1, 3);
        do_cfg(16, 0, 1, 1);
        do_pend(16, 0);
        do_ack();
        chk_cand("R9 setup", 1, 17, 0, 4, 0, 2);
        do_der(12, 0, 1);
        chk_cand("R9 dropped", 1, 17, 0, 4, 0, 2);
        chk("R9 no der_err", int'(der_err), 0);
        do_cfg(12, 0, 1, 0);
        do_der(12, 0, 1);
        chk_cand("R9 urgent pended", 1, 12, 0, 1, 1, 2);

        do_der(5, 0, 1);
        chk_cand("R11 promoted", 1, 3, 0, 0, 1, 2);
        chk("R11 no lockup", int'(lockup), 0);

        do_der(3, 0, 1);
        chk("R10 lockup", int'(lockup), 1);
        do_ack();
        chk("R13 ack ignored exec", int'(exec_level), 2);
        chk("R13 ack ignored active", int'(active_mask[3]), 0);
        do_der(16, 0, 0);
        chk("R13 derived ignored", int'(der_err), 0);
        cyc();
        cyc();
        chk("R13 lockup held", int'(lockup), 1);

        // R10 negative: entry of a less urgent exception
        do_reset();
        do_cfg(16, 0, 1, 1);
        do_pend(16, 0);
        do_der(3, 0, 1);
        chk("R10 no lockup", int'(lockup), 0);
        chk_cand("R10 hard fault pended", 1, 3, 0, 0, 1, 15);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule